// File: doc/BRIEF.md
# Serial Configuration Memory Readout Controller

This block is the control logic of a serial configuration store. It holds a bitstream in a small word-organised array and streams it one bit per rising edge of a data clock. The output goes to the serial configuration input of a programmable logic device. A high-active enable line, `oe`, doubles as a restart: while it is low, the read position is cleared and the data line is released. A low-active select, `cs_n`, gates both the position counters and the data driver.

The read position has two parts. A bit index picks a bit within the current word. A word address advances each time the bit index wraps. Bits leave each word least significant first, and words leave in ascending address order.

After the final bit has been shown, the block releases the data line and pulls its cascade output low. The next store in a chain can then take over the shared line. The cascade output stays low until a restart. A preload write port fills the array, and it accepts writes only while `oe` is low. A power-on reset clears the position without any `oe` pulse.

Top module: `cfgmem_stream`

## Requirements
- R1: While `oe` is low, `dout_en` is 0 at once. Every rising edge with `oe` low returns the read position to word 0, bit 0 and sets `casc_n` back to 1.
- R2: When `oe` is high and `cs_n` is high, `dout_en` is 0 and the read position does not move. When `cs_n` returns low, streaming continues with the next unsent bit.
- R3: When `oe` is high and `cs_n` is low, each rising edge presents the next bit on `dout`, and `dout_en` is 1 after that edge. `dout` changes only on rising edges.
- R4: Each word is sent least significant bit first, and words are sent from address 0 to `DEPTH-1`. The word address advances when the bit index wraps from `WORD_W-1` to 0, so bit k of the stream is bit (k mod `WORD_W`) of word (k div `WORD_W`).
- R5: A restart through `oe` in the middle of a stream takes effect whatever the level of `cs_n`. The next enabled edge presents word 0, bit 0.
- R6: The enabled edge after the one that presented the last stored bit drives `casc_n` to 0, and `dout_en` is 0 from that edge on.
- R7: Once `casc_n` is 0, it stays 0 and nothing is driven until the next edge with `oe` low or a power-on reset. Further enabled edges have no effect.
- R8: While `por_n` is low, `casc_n` is 1 and `dout_en` is 0. After `por_n` is released, with no `oe` pulse, the first enabled edge presents word 0, bit 0.
- R9: When `wr_en` is 1, `wr_data` is stored at `wr_addr` on a rising edge only if `oe` is low on that edge. A write while `oe` is high leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all state changes on its rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| oe | input | 1 | Output enable; low clears the read position and releases data |
| cs_n | input | 1 | Chip select, active low; gates counting and driving |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | ADDR_W | Preload word address |
| wr_data | input | WORD_W | Preload word |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | Drive enable for `dout` (tri-state stand-in) |
| casc_n | output | 1 | Cascade hand-off, active low |

## Verification
The array is read out in full with three different fill patterns: one derived from an address hash, its complement, and one whose words alternate all-ones and all-zeros. These patterns expose a wrong bit order, a missed word advance and a stuck bit. Pausing and resuming with `cs_n` partway through a word shows whether the position freezes or skips. Two restarts are checked, one with `cs_n` high and one with it low. A write attempted while `oe` is high, followed by a later full readout, separates a gated write port from an ungated one. The edges after the final bit show whether the hand-off is timed and latched correctly.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
   // Number of bits needed to index n items (at least one)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Output stage phase
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHOW  = 2'd1,
      PH_FINAL = 2'd2,
      PH_DONE  = 2'd3
   } cfg_phase_e;
endpackage

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 4,
   localparam int ADDR_W = cfgmem_pkg::idx_w(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_ok,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_ok && wr_en && (int'(wr_addr) < DEPTH))
         cells[wr_addr] <= wr_data;
   end

   always_comb begin
      rd_word = '0;
      if (int'(rd_addr) < DEPTH)
         rd_word = cells[rd_addr];
   end
endmodule

// File: rtl/cfgmem_walker.sv
module cfgmem_walker #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 4,
   localparam int BIT_W  = cfgmem_pkg::idx_w(WORD_W),
   localparam int ADDR_W = cfgmem_pkg::idx_w(DEPTH)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clr,
   input  logic              step,
   output logic [BIT_W-1:0]  bit_q,
   output logic [ADDR_W-1:0] word_q,
   output logic              at_end
);
   logic             bit_last;
   logic [BIT_W-1:0] bit_nxt;

   generate
      if ((1 << BIT_W) == WORD_W) begin : g_pow2
         assign bit_last = &bit_q;
         assign bit_nxt  = bit_q + 1'b1;
      end else begin : g_cmp
         assign bit_last = (bit_q == BIT_W'(WORD_W - 1));
         assign bit_nxt  = bit_last ? '0 : bit_q + 1'b1;
      end
   endgenerate

   assign at_end = bit_last && (word_q == ADDR_W'(DEPTH - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         bit_q  <= '0;
         word_q <= '0;
      end else if (clr) begin
         bit_q  <= '0;
         word_q <= '0;
      end else if (step) begin
         bit_q <= bit_nxt;
         if (bit_last)
            word_q <= word_q + 1'b1;
      end
   end
endmodule

// File: rtl/cfgmem_emit.sv
module cfgmem_emit
   import cfgmem_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   input  logic en,
   input  logic bit_in,
   input  logic at_end,
   output logic step,
   output logic dout,
   output logic drv,
   output logic done
);
   cfg_phase_e ph_q;
   logic       dout_q;

   assign step = en && (ph_q != PH_FINAL) && (ph_q != PH_DONE) && !at_end;
   assign dout = dout_q;
   assign drv  = (ph_q == PH_SHOW) || (ph_q == PH_FINAL);
   assign done = (ph_q == PH_DONE);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ph_q   <= PH_IDLE;
         dout_q <= 1'b0;
      end else if (clr) begin
         ph_q   <= PH_IDLE;
         dout_q <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_DONE: ph_q <= PH_DONE;
            PH_FINAL: begin
               if (en) ph_q <= PH_DONE;
            end
            default: begin
               if (en) begin
                  dout_q <= bit_in;
                  ph_q   <= at_end ? PH_FINAL : PH_SHOW;
               end else begin
                  ph_q <= PH_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cfgmem_stream.sv
module cfgmem_stream #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 4,
   localparam int BIT_W  = cfgmem_pkg::idx_w(WORD_W),
   localparam int ADDR_W = cfgmem_pkg::idx_w(DEPTH)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              oe,
   input  logic              cs_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic              dout,
   output logic              dout_en,
   output logic              casc_n
);
   initial begin
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
      assert (DEPTH >= 2)  else $error("DEPTH must be at least 2");
   end

   logic [BIT_W-1:0]  bit_q;
   logic [ADDR_W-1:0] word_q;
   logic [WORD_W-1:0] rd_word;
   logic              at_end, step, drv, done, bit_sel;
   logic              run_en;

   assign run_en  = oe && !cs_n;
   assign bit_sel = rd_word[bit_q];

   cfgmem_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_array (
      .clk     (clk),
      .wr_ok   (!oe),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (word_q),
      .rd_word (rd_word)
   );

   cfgmem_walker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_walk (
      .clk    (clk),
      .por_n  (por_n),
      .clr    (!oe),
      .step   (step),
      .bit_q  (bit_q),
      .word_q (word_q),
      .at_end (at_end)
   );

   cfgmem_emit u_emit (
      .clk    (clk),
      .por_n  (por_n),
      .clr    (!oe),
      .en     (run_en),
      .bit_in (bit_sel),
      .at_end (at_end),
      .step   (step),
      .dout   (dout),
      .drv    (drv),
      .done   (done)
   );

   assign dout_en = drv && run_en;
   assign casc_n  = !done;
endmodule

// File: rtl/cfgmem_chk.sv
module cfgmem_chk #(
   parameter int BIT_W  = 3,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              por_n,
   input logic              oe,
   input logic              cs_n,
   input logic              dout_en,
   input logic              casc_n,
   input logic [BIT_W-1:0]  bit_cnt,
   input logic [ADDR_W-1:0] word_cnt
);
   AST_OE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      !oe |=> (bit_cnt == '0 && word_cnt == '0 && casc_n)) // R1
      else $error("oe low did not clear position");

   AST_CS_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
      (oe && cs_n) |=> ($stable(bit_cnt) && $stable(word_cnt))) // R2
      else $error("position moved while deselected");

   AST_DRIVE_RUN: assert property (@(posedge clk) disable iff (!por_n)
      (oe && !cs_n && casc_n) |=> (!oe || cs_n || !casc_n || dout_en)) // R3
      else $error("data not driven while running");

   AST_CASC_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
      !casc_n |-> !dout_en) // R6
      else $error("data driven after hand-off");

   AST_CASC_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (!casc_n && oe) |=> (!casc_n && $stable(bit_cnt) && $stable(word_cnt))) // R7
      else $error("hand-off not held");
endmodule

bind cfgmem_stream cfgmem_chk #(.BIT_W(BIT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .oe       (oe),
   .cs_n     (cs_n),
   .dout_en  (dout_en),
   .casc_n   (casc_n),
   .bit_cnt  (bit_q),
   .word_cnt (word_q)
);

// File: tb/sim_cfgmem_stream.sv
`timescale 1ns/1ps
module sim_cfgmem_stream;
   localparam int WORD_W = 8;
   localparam int DEPTH  = 4;
   localparam int ADDR_W = 2;
   localparam int NBITS  = WORD_W * DEPTH;

   logic clk = 1'b0;
   logic por_n = 1'b0, oe = 1'b0, cs_n = 1'b1, wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [WORD_W-1:0] wr_data = '0;
   logic dout, dout_en, casc_n;

   logic [WORD_W-1:0] model [DEPTH];
   int checks = 0, fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cfgmem_stream #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .por_n(por_n), .oe(oe), .cs_n(cs_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .dout(dout), .dout_en(dout_en), .casc_n(casc_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // one rising edge, then settle away from it
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   function automatic logic exp_bit(input int k);
      return model[k / WORD_W][k % WORD_W];
   endfunction

   task automatic load(input int pat);
      oe = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         case (pat)
            0: model[i] = WORD_W'((i * 37 + 5) ^ 8'hA5);
            1: model[i] = ~WORD_W'((i * 37 + 5) ^ 8'hA5);
            default: model[i] = (i % 2 == 0) ? '1 : '0;
         endcase
         wr_en = 1'b1; wr_addr = ADDR_W'(i); wr_data = model[i];
         tick();
      end
      wr_en = 1'b0;
   endtask

   // stream bits [from, to) with cs_n low, checking each
   task automatic stream(input int from, input int to, input string req);
      cs_n = 1'b0; oe = 1'b1;
      for (int k = from; k < to; k++) begin
         tick();
         chk({req, " dout"}, dout, exp_bit(k));
         chk({req, " dout_en"}, dout_en, 1'b1);
         chk({req, " casc_n"}, casc_n, 1'b1);
      end
   endtask

   task automatic check_handoff();
      tick();
      chk("R6 casc_n low after last bit", casc_n, 1'b0);
      chk("R6 dout_en released", dout_en, 1'b0);
      for (int j = 0; j < 3; j++) begin
         tick();
         chk("R7 casc_n held", casc_n, 1'b0);
         chk("R7 dout_en held off", dout_en, 1'b0);
      end
   endtask

   task automatic restart();
      oe = 1'b0;
      #1 chk("R1 dout_en off with oe low", dout_en, 1'b0);
      tick();
      chk("R1 casc_n back high", casc_n, 1'b1);
      chk("R1 dout_en off", dout_en, 1'b0);
   endtask

   initial begin
      #20;
      chk("R8 casc_n in reset", casc_n, 1'b1);
      chk("R8 dout_en in reset", dout_en, 1'b0);
      load(0);
      // R8: release power-on reset with select already active, no oe pulse
      oe = 1'b1; cs_n = 1'b0;
      #1 por_n = 1'b1;
      stream(0, NBITS, "R8 R3 R4 power-up stream");
      check_handoff();

      // R2: deselect after restart
      restart();
      oe = 1'b1; cs_n = 1'b1;
      for (int j = 0; j < 3; j++) begin
         tick();
         chk("R2 idle dout_en", dout_en, 1'b0);
      end
      stream(0, 11, "R2 R4 first part");
      cs_n = 1'b1;
      #1 chk("R2 deselect dout_en", dout_en, 1'b0);
      for (int j = 0; j < 5; j++) begin
         tick();
         chk("R2 frozen dout_en", dout_en, 1'b0);
         chk("R2 frozen casc_n", casc_n, 1'b1);
      end
      stream(11, 20, "R2 resume");
      // R9: write attempt with oe high must be ignored
      wr_en = 1'b1; wr_addr = '0; wr_data = ~model[0];
      tick();
      chk("R9 stream during write attempt", dout, exp_bit(20));
      wr_en = 1'b0;
      // R5: restart with cs_n high
      cs_n = 1'b1;
      restart();
      stream(0, NBITS, "R5 R9 after restart (cs_n high)");
      check_handoff();

      // R5: restart with cs_n low in mid stream
      restart();
      stream(0, 13, "R5 prefix");
      restart();
      stream(0, NBITS, "R5 after restart (cs_n low)");
      check_handoff();

      // further patterns, preload with oe low (R9 accepted writes)
      for (int p = 1; p < 3; p++) begin
         load(p);
         restart();
         stream(0, NBITS, "R9 R4 new pattern");
         check_handoff();
      end

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule